// File: doc/BRIEF.md
# Flag-Indexed Microcode Sequencer

This block forms the address of a microcode ROM. It counts the microinstruction steps within a machine instruction and presents that count together with the opcode, an interrupt indicator and a held copy of the ALU condition flags. Because the flag bits sit directly in the ROM address, a microcode routine branches on a condition simply by having different ROM contents at the two flag-dependent addresses. A separate branch field is not needed.

The microcode word drives two control bits into the block. The restart bit ends the current instruction. At that edge the counter returns to zero, and the incoming opcode and the interrupt-taken indication are latched for the next instruction. The flag-reload bit copies the live flag inputs into the local flag register. Only that command updates the flag register, so a flag change in the middle of an instruction does not alter the address path. A stall input, raised while a bus request is in progress, freezes the counter, the opcode and the interrupt bit for that cycle.

Top module: `useq_addr_gen`

## Requirements
- R1: The address is laid out as follows: bits 3:0 are the step counter, bit 4 is the held sign/immediate-sign flag, bit 5 is the held zero flag, bit 6 is the held overflow flag, bit 7 is the held carry flag, bit 8 is the held interrupt bit, and bits 16:9 are the held opcode.
- R2: When `rst`, `stall` and `restart` are all low at a rising edge, the step field increments by one. It wraps from 15 to 0.
- R3: When `restart` is high and `stall` is low at a rising edge, the step field becomes 0. In the same edge, bits 16:9 take `opcode` and bit 8 takes `irq_take`.
- R4: Changes on `opcode` and `irq_take` have no effect on the address except at an edge where R3 applies.
- R5: When `stall` is high at a rising edge, the step, opcode and interrupt fields keep their values and `restart` is ignored.
- R6: When `flag_reload` is high at a rising edge, bits 7:4 take {`carry_in`, `ovf_in`, `zero_in`, `sign_in`}. This happens whatever the value of `stall`.
- R7: When `flag_reload` is low at a rising edge, bits 7:4 keep their value.
- R8: `rst` is synchronous and active high, and it dominates all other inputs. After an edge with `rst` high, the whole address is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Microcode bit that ends the instruction and restarts the step count |
| flag_reload | input | 1 | Microcode bit that refreshes the held flags |
| carry_in | input | 1 | Live carry flag |
| ovf_in | input | 1 | Live overflow flag |
| zero_in | input | 1 | Live zero flag |
| sign_in | input | 1 | Live sign flag or immediate sign bit |
| irq_take | input | 1 | Interrupt to be taken at the next instruction start |
| opcode | input | 8 | Opcode of the next instruction |
| stall | input | 1 | Bus request in progress; holds the sequence |
| rom_addr | output | 17 | Microcode ROM address |

## Verification
Every field of the address comes straight from a register, so a corrupted counter, flag, interrupt or opcode state appears on `rom_addr` in the cycle after the faulty edge. The bench therefore compares each field with a behavioural model after every edge. It names the rule that governs that edge: increment, restart, stall hold, flag reload or reset. The stimulus includes long runs without restart, which take the counter through its wrap. It also includes stalls that coincide with restart, and flag changes while reload is low.

// File: rtl/useq_addr_gen.sv
module useq_addr_gen #(
  parameter int STEP_W = 4,
  parameter int OP_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        restart,
  input  logic                        flag_reload,
  input  logic                        carry_in,
  input  logic                        ovf_in,
  input  logic                        zero_in,
  input  logic                        sign_in,
  input  logic                        irq_take,
  input  logic [OP_W-1:0]             opcode,
  input  logic                        stall,
  output logic [OP_W+STEP_W+4:0]      rom_addr
);

  localparam int FLAG_W = 4;

  logic [STEP_W-1:0] step_q;
  logic [FLAG_W-1:0] flags_q;
  logic              irq_q;
  logic [OP_W-1:0]   op_q;

  wire advance = !stall && !restart;
  wire begin_instr = !stall && restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      irq_q  <= 1'b0;
      op_q   <= '0;
    end else if (begin_instr) begin
      step_q <= '0;
      irq_q  <= irq_take;
      op_q   <= opcode;
    end else if (advance) begin
      step_q <= step_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      flags_q <= '0;
    else if (flag_reload)
      flags_q <= {carry_in, ovf_in, zero_in, sign_in};
  end

  assign rom_addr = {op_q, irq_q, flags_q, step_q};

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && !restart) |=> rom_addr[STEP_W-1:0] == $past(rom_addr[STEP_W-1:0]) + 1'b1);

  // R3
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!stall && restart) |=> (rom_addr[STEP_W-1:0] == '0) &&
      (rom_addr[OP_W+STEP_W+4:STEP_W+5] == $past(opcode)) &&
      (rom_addr[STEP_W+4] == $past(irq_take)));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(rom_addr[STEP_W-1:0]) && $stable(rom_addr[OP_W+STEP_W+4:STEP_W+4]));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    flag_reload |=> rom_addr[STEP_W+3:STEP_W] == $past({carry_in, ovf_in, zero_in, sign_in}));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_reload |=> $stable(rom_addr[STEP_W+3:STEP_W]));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> rom_addr == '0);

endmodule

// File: tb/useq_addr_gen_tb.sv
module useq_addr_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic restart = 1'b0, flag_reload = 1'b0, stall = 1'b0;
  logic carry_in = 1'b0, ovf_in = 1'b0, zero_in = 1'b0, sign_in = 1'b0, irq_take = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [16:0] rom_addr;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  int m_step = 0, m_flags = 0, m_irq = 0, m_op = 0;
  string tag_step = "R8", tag_flag = "R8", tag_op = "R8";

  useq_addr_gen dut_i (
    .clk(clk), .rst(rst), .restart(restart), .flag_reload(flag_reload),
    .carry_in(carry_in), .ovf_in(ovf_in), .zero_in(zero_in), .sign_in(sign_in),
    .irq_take(irq_take), .opcode(opcode), .stall(stall), .rom_addr(rom_addr)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_step = 0; m_flags = 0; m_irq = 0; m_op = 0;
      tag_step = "R8"; tag_flag = "R8"; tag_op = "R8";
    end else begin
      if (flag_reload) begin
        m_flags = carry_in * 8 + ovf_in * 4 + zero_in * 2 + sign_in;
        tag_flag = "R6";
      end else tag_flag = "R7";
      if (stall) begin
        tag_step = "R5"; tag_op = "R5";
      end else if (restart) begin
        m_step = 0; m_op = opcode; m_irq = irq_take;
        tag_step = "R3"; tag_op = "R3";
      end else begin
        m_step = (m_step + 1) % 16;
        tag_step = "R2"; tag_op = "R4";
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(tag_step, rom_addr[3:0], m_step);
    chk(tag_flag, rom_addr[7:4], m_flags);
    chk(tag_op, rom_addr[8], m_irq);
    chk(tag_op, rom_addr[16:9], m_op);
    // R1: whole address against the field layout
    chk("R1", rom_addr, m_op * 512 + m_irq * 256 + m_flags * 16 + m_step);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic cyc(input int mode);
    @(negedge clk);
    check_all();
    lfsr = nxt(lfsr);
    rst = 1'b0;
    {carry_in, ovf_in, zero_in, sign_in} = lfsr[3:0];
    irq_take = lfsr[4];
    opcode = lfsr[12:5];
    flag_reload = (lfsr[15:13] == 3'd0);
    case (mode)
      0: begin restart = 1'b0; stall = 1'b0; end
      1: begin restart = (lfsr[7:5] == 3'd0); stall = (lfsr[10:8] == 3'd0); end
      2: begin restart = lfsr[6]; stall = lfsr[9]; end
      default: begin rst = 1'b1; restart = lfsr[6]; stall = lfsr[9]; flag_reload = 1'b1; end
    endcase
  endtask

  initial begin
    repeat (3) cyc(3);
    // R2: long run without restart covers the 15 to 0 wrap
    repeat (40) cyc(0);
    repeat (400) cyc(1);
    // R5: dense stalls, often together with restart
    repeat (300) cyc(2);
    // R8: reset in mid-sequence
    repeat (2) cyc(3);
    repeat (200) cyc(1);
    @(negedge clk);
    check_all();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule